// File: doc/BRIEF.md
# Security-Filtered Private Interrupt Register Bank

This block is the memory-mapped state store for the 32 private interrupts of one processor core. It keeps, for each interrupt, a group bit, an enable bit, a pending bit, an active bit, an 8-bit priority and an edge/level trigger bit. It also holds two 32-bit control words that only a privileged agent may use: a group-modifier word and a non-secure access-control word. Software reaches all of this through a simple bus with an address, a size code, read and write strobes, write data and a secure attribute. A global input can switch the security model off altogether.

Every access goes through a filter. When an agent is non-secure and security is on, it is "restricted". Such an agent sees and changes only the interrupts whose group bit is 1. It sees their priorities in a shifted view: the value it reads is the stored value shifted up by one bit. On a write, the value it supplies is converted back, so it can only place its interrupts in the lower-urgency half of the priority range. The priority array can be reached one byte at a time or four interrupts at a time. Accesses to offsets or sizes the block does not decode always complete: a read of one returns zero and a write to one is dropped. Arbitration between interrupts and signalling to the core are left to other blocks.

Top module: `pirq_regbank`

## Requirements
- R1: For a restricted access (bus_secure=0 and sec_disable=0), the enable, pending and active set/clear registers read only the bits whose group bit is 1 and change only those bits on a write. For every other access, all 32 bits are visible.
- R2: A write to a set address ORs the filtered data into its bitmap. A write to a clear address removes the filtered data bits from it. Both addresses of a pair read back the same value.
- R3: A restricted read of a priority returns 0 for a group-0 interrupt. For a group-1 interrupt it returns the stored value shifted left by one and truncated to 8 bits. Unrestricted reads return the stored value.
- R4: A restricted priority write to a group-0 interrupt leaves the priority unchanged. For a group-1 interrupt it stores 0x80 ORed with the written byte shifted right by one. Unrestricted writes store the byte as given.
- R5: The priority window is 32 bytes long and starts at offset 0x100. A byte access (size code 0) reaches interrupt addr[4:0], with the data in bits 7:0. A word access (size code 2) at a 4-aligned offset covers four consecutive interrupts, and the lowest-numbered one is in bits 7:0.
- R6: The group register reads as 0 to a restricted agent and ignores that agent's writes. Any other agent reads and writes it in full.
- R7: The group-modifier and access-control registers read as 0, and ignore writes, unless bus_secure=1 and sec_disable=0.
- R8: The pending registers read as the stored pending bits ORed with irq_level for the interrupts whose edge bit is 0.
- R9: The upper configuration register (interrupts 16..31) shows the edge bit of interrupt 16+n at bit 2n+1, and all its other bits read as 0. A write to it updates only the edge bits that pass the group filter. Writes to the lower configuration register (interrupts 0..15) are ignored, and it reads those edge bits in the same layout.
- R10: Accesses to an undefined offset, with size code 1 or 3, with a byte size outside the priority window, or with a misaligned word in the priority window, complete without effect. A read of one returns 0.
- R11: All state resets to 0, priorities included. A write takes effect at the clock edge where the write strobe is sampled. Read data is registered at the edge where the read strobe is sampled and holds until the next read.
- R12: The word registers sit at these offsets: group 0x000, enable set/clear 0x004/0x008, pending set/clear 0x00C/0x010, active set/clear 0x014/0x018, lower/upper configuration 0x01C/0x020, group modifier 0x024, access control 0x028. Each is reached only with size code 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_size | input | 2 | Size code: 0 byte, 2 word, 1 and 3 unsupported |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | Secure attribute of the access |
| sec_disable | input | 1 | Global security disable |
| irq_level | input | 32 | Current line level of each interrupt |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench builds the block with its default parameters: 32 interrupts, 8-bit priorities and a 12-bit offset. At these values a single word access covers exactly four priority lanes, and the upper configuration register spans all 16 upper edge bits. This lets the bench check the lane order, the shifted priority view at both byte and word width, and the bit-2n+1 configuration layout with split group masks. With interrupts 16..30 in group 1 and interrupt 31 in group 0, one word write shows both the filtered and the protected bits side by side.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int NUM_IRQ = 32;
    localparam int PRIO_W  = 8;
    localparam int ADDR_W  = 12;

    localparam logic [11:0] OFF_GROUP    = 12'h000;
    localparam logic [11:0] OFF_EN_SET   = 12'h004;
    localparam logic [11:0] OFF_EN_CLR   = 12'h008;
    localparam logic [11:0] OFF_PEND_SET = 12'h00C;
    localparam logic [11:0] OFF_PEND_CLR = 12'h010;
    localparam logic [11:0] OFF_ACT_SET  = 12'h014;
    localparam logic [11:0] OFF_ACT_CLR  = 12'h018;
    localparam logic [11:0] OFF_CFG_LO   = 12'h01C;
    localparam logic [11:0] OFF_CFG_HI   = 12'h020;
    localparam logic [11:0] OFF_GRPMOD   = 12'h024;
    localparam logic [11:0] OFF_NSCTL    = 12'h028;
    localparam logic [11:0] OFF_PRIO     = 12'h100;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic grp;
        logic en_set;
        logic en_clr;
        logic pend_set;
        logic pend_clr;
        logic act_set;
        logic act_clr;
        logic cfg_lo;
        logic cfg_hi;
        logic grpmod;
        logic nsctl;
        logic prio;
        logic known;
    } reg_sel_t;

    // Priority as shown to the requesting agent
    function automatic logic [PRIO_W-1:0] prio_view(input logic [PRIO_W-1:0] stored,
                                                    input logic restricted,
                                                    input logic grp_bit);
        if (!restricted)
            return stored;
        if (!grp_bit)
            return '0;
        return {stored[PRIO_W-2:0], 1'b0};
    endfunction

    // Priority as stored after a write from the requesting agent
    function automatic logic [PRIO_W-1:0] prio_store(input logic [PRIO_W-1:0] value,
                                                     input logic restricted);
        if (!restricted)
            return value;
        return {1'b1, value[PRIO_W-1:1]};
    endfunction

endpackage

// File: rtl/pirq_access_filter.sv
module pirq_access_filter
    import pirq_pkg::*;
#(
    parameter int N = NUM_IRQ
) (
    input  logic         bus_secure,
    input  logic         sec_disable,
    input  logic [N-1:0] grp,
    output logic         restricted,
    output logic         privileged,
    output logic [N-1:0] vis_mask
);

    always_comb begin
        restricted = !bus_secure && !sec_disable;
        privileged = bus_secure && !sec_disable;
        vis_mask   = restricted ? grp : {N{1'b1}};
    end

endmodule

// File: rtl/pirq_addr_decode.sv
module pirq_addr_decode
    import pirq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int N  = NUM_IRQ,
    parameter int PW = PRIO_W
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    output reg_sel_t      sel,
    output logic [N-1:0]  lane_hit
);

    localparam int IW = $clog2(N);
    localparam int NL = N / PW;
    localparam int LW = $clog2(NL);
    localparam int HW = IW - LW;
    localparam logic [AW-1:0] WIN = AW'(OFF_PRIO);

    logic word_acc;
    logic byte_acc;
    logic in_win;

    assign word_acc = acc_size_e'(size) == SZ_WORD;
    assign byte_acc = acc_size_e'(size) == SZ_BYTE;
    assign in_win   = addr[AW-1:IW] == WIN[AW-1:IW];

    for (genvar i = 0; i < N; i++) begin : g_lane
        assign lane_hit[i] = in_win &&
            ((byte_acc && addr[IW-1:0] == IW'(i)) ||
             (word_acc && addr[LW-1:0] == '0 && addr[IW-1:LW] == HW'(i / NL)));
    end

    always_comb begin
        sel          = '0;
        sel.grp      = word_acc && addr == AW'(OFF_GROUP);
        sel.en_set   = word_acc && addr == AW'(OFF_EN_SET);
        sel.en_clr   = word_acc && addr == AW'(OFF_EN_CLR);
        sel.pend_set = word_acc && addr == AW'(OFF_PEND_SET);
        sel.pend_clr = word_acc && addr == AW'(OFF_PEND_CLR);
        sel.act_set  = word_acc && addr == AW'(OFF_ACT_SET);
        sel.act_clr  = word_acc && addr == AW'(OFF_ACT_CLR);
        sel.cfg_lo   = word_acc && addr == AW'(OFF_CFG_LO);
        sel.cfg_hi   = word_acc && addr == AW'(OFF_CFG_HI);
        sel.grpmod   = word_acc && addr == AW'(OFF_GRPMOD);
        sel.nsctl    = word_acc && addr == AW'(OFF_NSCTL);
        sel.prio     = |lane_hit;
        sel.known    = sel.grp | sel.en_set | sel.en_clr | sel.pend_set |
                       sel.pend_clr | sel.act_set | sel.act_clr | sel.cfg_lo |
                       sel.cfg_hi | sel.grpmod | sel.nsctl | sel.prio;
    end

endmodule

// File: rtl/pirq_prio_array.sv
module pirq_prio_array
    import pirq_pkg::*;
#(
    parameter int N  = NUM_IRQ,
    parameter int PW = PRIO_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  lane_we,
    input  logic [N*PW-1:0] lane_wdata,
    input  logic          restricted,
    input  logic [N-1:0]  grp,
    output logic [N*PW-1:0] prio_flat
);

    logic [PW-1:0] prio_d [N];
    logic [PW-1:0] prio_q [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            prio_d[i] = prio_q[i];
            if (lane_we[i] && !(restricted && !grp[i]))
                prio_d[i] = prio_store(lane_wdata[i*PW +: PW], restricted);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++)
                prio_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++)
                prio_q[i] <= prio_d[i];
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_out
        assign prio_flat[i*PW +: PW] = prio_q[i];
    end

endmodule

// File: rtl/pirq_regbank.sv
module pirq_regbank
    import pirq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int N  = NUM_IRQ,
    parameter int PW = PRIO_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [1:0]    bus_size,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [N-1:0]  bus_wdata,
    input  logic          bus_secure,
    input  logic          sec_disable,
    input  logic [N-1:0]  irq_level,
    output logic [N-1:0]  bus_rdata
);

    localparam int NL   = N / PW;
    localparam int HALF = N / 2;

    typedef struct packed {
        logic [N-1:0] grp;
        logic [N-1:0] en;
        logic [N-1:0] pend;
        logic [N-1:0] act;
        logic [N-1:0] edge_cfg;
        logic [N-1:0] grpmod;
        logic [N-1:0] nsctl;
        logic [N-1:0] rdata;
    } bank_t;

    bank_t           bank_d;
    bank_t           bank_q;
    reg_sel_t        sel;
    logic [N-1:0]    lane_hit;
    logic [N*PW-1:0] lane_wdata;
    logic [N*PW-1:0] prio_flat;
    logic            restricted;
    logic            privileged;
    logic [N-1:0]    vis_mask;
    logic            byte_acc;

    assign byte_acc = acc_size_e'(bus_size) == SZ_BYTE;

    pirq_access_filter #(.N(N)) u_filter (
        .bus_secure  (bus_secure),
        .sec_disable (sec_disable),
        .grp         (bank_q.grp),
        .restricted  (restricted),
        .privileged  (privileged),
        .vis_mask    (vis_mask)
    );

    pirq_addr_decode #(.AW(AW), .N(N), .PW(PW)) u_decode (
        .addr     (bus_addr),
        .size     (bus_size),
        .sel      (sel),
        .lane_hit (lane_hit)
    );

    for (genvar i = 0; i < N; i++) begin : g_wlane
        assign lane_wdata[i*PW +: PW] = byte_acc ? bus_wdata[PW-1:0]
                                                 : bus_wdata[(i % NL)*PW +: PW];
    end

    pirq_prio_array #(.N(N), .PW(PW)) u_prio (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_we    (lane_hit & {N{bus_wr}}),
        .lane_wdata (lane_wdata),
        .restricted (restricted),
        .grp        (bank_q.grp),
        .prio_flat  (prio_flat)
    );

    always_comb begin
        logic [N-1:0]  rd_val;
        logic [N-1:0]  pend_view;
        logic [PW-1:0] pv;

        bank_d    = bank_q;
        rd_val    = '0;
        pv        = '0;
        pend_view = bank_q.pend | (irq_level & ~bank_q.edge_cfg);

        if (bus_wr) begin
            if (sel.grp && !restricted)
                bank_d.grp = bus_wdata;
            if (sel.en_set)
                bank_d.en = bank_q.en | (bus_wdata & vis_mask);
            if (sel.en_clr)
                bank_d.en = bank_q.en & ~(bus_wdata & vis_mask);
            if (sel.pend_set)
                bank_d.pend = bank_q.pend | (bus_wdata & vis_mask);
            if (sel.pend_clr)
                bank_d.pend = bank_q.pend & ~(bus_wdata & vis_mask);
            if (sel.act_set)
                bank_d.act = bank_q.act | (bus_wdata & vis_mask);
            if (sel.act_clr)
                bank_d.act = bank_q.act & ~(bus_wdata & vis_mask);
            if (sel.cfg_hi) begin
                for (int n = 0; n < HALF; n++) begin
                    if (vis_mask[HALF+n])
                        bank_d.edge_cfg[HALF+n] = bus_wdata[2*n+1];
                end
            end
            if (sel.grpmod && privileged)
                bank_d.grpmod = bus_wdata;
            if (sel.nsctl && privileged)
                bank_d.nsctl = bus_wdata;
        end

        if (bus_rd) begin
            if (sel.grp && !restricted)
                rd_val = bank_q.grp;
            if (sel.en_set || sel.en_clr)
                rd_val = bank_q.en & vis_mask;
            if (sel.pend_set || sel.pend_clr)
                rd_val = pend_view & vis_mask;
            if (sel.act_set || sel.act_clr)
                rd_val = bank_q.act & vis_mask;
            if (sel.cfg_lo) begin
                for (int n = 0; n < HALF; n++)
                    rd_val[2*n+1] = bank_q.edge_cfg[n] & vis_mask[n];
            end
            if (sel.cfg_hi) begin
                for (int n = 0; n < HALF; n++)
                    rd_val[2*n+1] = bank_q.edge_cfg[HALF+n] & vis_mask[HALF+n];
            end
            if (sel.grpmod && privileged)
                rd_val = bank_q.grpmod;
            if (sel.nsctl && privileged)
                rd_val = bank_q.nsctl;
            if (sel.prio) begin
                for (int i = 0; i < N; i++) begin
                    if (lane_hit[i]) begin
                        pv = prio_view(prio_flat[i*PW +: PW], restricted, bank_q.grp[i]);
                        if (byte_acc)
                            rd_val[PW-1:0] = pv;
                        else
                            rd_val[(i % NL)*PW +: PW] = pv;
                    end
                end
            end
            if (!sel.known)
                rd_val = '0;
            bank_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bank_q <= '0;
        else
            bank_q <= bank_d;
    end

    assign bus_rdata = bank_q.rdata;

endmodule

// File: rtl/pirq_regbank_chk.sv
module pirq_regbank_chk #(
    parameter int AW = 12,
    parameter int N  = 32,
    parameter int PW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic [1:0]    bus_size,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic          bus_secure,
    input logic          sec_disable,
    input logic [N-1:0]  bus_rdata,
    input logic [N-1:0]  grp_q,
    input logic [N-1:0]  en_q,
    input logic [N-1:0]  grpmod_q,
    input logic [N-1:0]  nsctl_q,
    input logic [N*PW-1:0] prio_flat
);

    localparam int IW = $clog2(N);

    logic limited;
    logic in_prio;

    assign limited = !bus_secure && !sec_disable;
    assign in_prio = bus_addr[AW-1:IW] == (AW-IW)'(12'h100 >> IW);

    // R1
    en_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && limited) |=> (((en_q ^ $past(en_q)) & ~$past(grp_q)) == '0));

    // R6
    grp_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && limited) |=> $stable(grp_q));

    // R7
    priv_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !(bus_secure && !sec_disable)) |=> ($stable(grpmod_q) && $stable(nsctl_q)));

    // R3
    prio_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && limited && bus_size == 2'd0 && in_prio && !grp_q[bus_addr[IW-1:0]])
        |=> (bus_rdata == '0));

    // R4
    prio_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && limited && bus_size == 2'd0 && in_prio && grp_q[bus_addr[IW-1:0]])
        |=> prio_flat[$past(bus_addr[IW-1:0])*PW + PW-1]);

    // R10
    bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_size == 2'd1 || bus_size == 2'd3)) |=> (bus_rdata == '0));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

bind pirq_regbank pirq_regbank_chk #(.AW(AW), .N(N), .PW(PW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_size    (bus_size),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_secure  (bus_secure),
    .sec_disable (sec_disable),
    .bus_rdata   (bus_rdata),
    .grp_q       (bank_q.grp),
    .en_q        (bank_q.en),
    .grpmod_q    (bank_q.grpmod),
    .nsctl_q     (bank_q.nsctl),
    .prio_flat   (prio_flat)
);

// File: tb/tb_pirq_regbank.sv
module tb_pirq_regbank;

    localparam int CLK_PERIOD = 10;

    localparam logic [11:0] A_GRP = 12'h000;
    localparam logic [11:0] A_ES  = 12'h004;
    localparam logic [11:0] A_EC  = 12'h008;
    localparam logic [11:0] A_PS  = 12'h00C;
    localparam logic [11:0] A_PC  = 12'h010;
    localparam logic [11:0] A_AS  = 12'h014;
    localparam logic [11:0] A_AC  = 12'h018;
    localparam logic [11:0] A_CL  = 12'h01C;
    localparam logic [11:0] A_CH  = 12'h020;
    localparam logic [11:0] A_GM  = 12'h024;
    localparam logic [11:0] A_NS  = 12'h028;
    localparam logic [11:0] A_PR  = 12'h100;
    localparam logic [11:0] A_NONE = 12'h040;

    localparam logic [1:0] SB = 2'd0;
    localparam logic [1:0] SH = 2'd1;
    localparam logic [1:0] SW = 2'd2;
    localparam logic [1:0] SD = 2'd3;

    typedef struct packed {
        logic        wr;
        logic        sec;
        logic        dis;
        logic [1:0]  size;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 58;
    localparam vec_t TBL [NV] = '{
        // R6 group register visibility
        '{1'b1, 1'b1, 1'b0, SW, A_GRP, 32'hFFFF0000, 32'h0, 4'd6},
        '{1'b0, 1'b1, 1'b0, SW, A_GRP, 32'h0, 32'hFFFF0000, 4'd6},
        '{1'b0, 1'b0, 1'b0, SW, A_GRP, 32'h0, 32'h00000000, 4'd6},
        '{1'b1, 1'b0, 1'b0, SW, A_GRP, 32'hFFFFFFFF, 32'h0, 4'd6},
        '{1'b0, 1'b1, 1'b0, SW, A_GRP, 32'h0, 32'hFFFF0000, 4'd6},
        '{1'b0, 1'b0, 1'b1, SW, A_GRP, 32'h0, 32'hFFFF0000, 4'd6},
        // R1 R2 enable and active bitmaps
        '{1'b1, 1'b0, 1'b0, SW, A_ES, 32'hFFFFFFFF, 32'h0, 4'd1},
        '{1'b0, 1'b1, 1'b0, SW, A_EC, 32'h0, 32'hFFFF0000, 4'd2},
        '{1'b1, 1'b1, 1'b0, SW, A_ES, 32'h0000000F, 32'h0, 4'd2},
        '{1'b0, 1'b0, 1'b0, SW, A_ES, 32'h0, 32'hFFFF0000, 4'd1},
        '{1'b1, 1'b0, 1'b0, SW, A_EC, 32'hFFFFFFFF, 32'h0, 4'd1},
        '{1'b0, 1'b1, 1'b0, SW, A_ES, 32'h0, 32'h0000000F, 4'd2},
        '{1'b1, 1'b1, 1'b0, SW, A_AS, 32'h00F000F0, 32'h0, 4'd2},
        '{1'b1, 1'b1, 1'b0, SW, A_AC, 32'h00100010, 32'h0, 4'd2},
        '{1'b0, 1'b1, 1'b0, SW, A_AS, 32'h0, 32'h00E000E0, 4'd2},
        '{1'b0, 1'b1, 1'b0, SW, A_AC, 32'h0, 32'h00E000E0, 4'd2},
        // R3 R4 R5 priorities
        '{1'b1, 1'b1, 1'b0, SW, A_PR, 32'h44332211, 32'h0, 4'd5},
        '{1'b0, 1'b1, 1'b0, SB, A_PR + 12'd2, 32'h0, 32'h00000033, 4'd5},
        '{1'b0, 1'b0, 1'b0, SW, A_PR, 32'h0, 32'h00000000, 4'd3},
        '{1'b1, 1'b0, 1'b0, SB, A_PR + 12'd1, 32'hFF, 32'h0, 4'd4},
        '{1'b0, 1'b1, 1'b0, SW, A_PR, 32'h0, 32'h44332211, 4'd4},
        '{1'b1, 1'b1, 1'b0, SW, A_PR + 12'h10, 32'h80604020, 32'h0, 4'd5},
        '{1'b0, 1'b0, 1'b0, SW, A_PR + 12'h10, 32'h0, 32'h00C08040, 4'd3},
        '{1'b1, 1'b0, 1'b0, SB, A_PR + 12'h11, 32'h10, 32'h0, 4'd4},
        '{1'b0, 1'b1, 1'b0, SB, A_PR + 12'h11, 32'h0, 32'h00000088, 4'd4},
        '{1'b0, 1'b0, 1'b0, SB, A_PR + 12'h11, 32'h0, 32'h00000010, 4'd3},
        '{1'b1, 1'b0, 1'b1, SB, A_PR + 12'd5, 32'hAB, 32'h0, 4'd4},
        '{1'b0, 1'b0, 1'b1, SB, A_PR + 12'd5, 32'h0, 32'h000000AB, 4'd3},
        '{1'b0, 1'b1, 1'b0, SW, A_PR + 12'd4, 32'h0, 32'h0000AB00, 4'd5},
        // R9 trigger configuration
        '{1'b1, 1'b1, 1'b0, SW, A_CH, 32'h80000002, 32'h0, 4'd9},
        '{1'b0, 1'b1, 1'b0, SW, A_CH, 32'h0, 32'h80000002, 4'd9},
        '{1'b1, 1'b1, 1'b0, SW, A_CL, 32'hFFFFFFFF, 32'h0, 4'd9},
        '{1'b0, 1'b1, 1'b0, SW, A_CL, 32'h0, 32'h00000000, 4'd9},
        '{1'b1, 1'b1, 1'b0, SW, A_GRP, 32'h7FFF0000, 32'h0, 4'd9},
        '{1'b1, 1'b0, 1'b0, SW, A_CH, 32'h00000000, 32'h0, 4'd9},
        '{1'b0, 1'b1, 1'b0, SW, A_CH, 32'h0, 32'h80000000, 4'd9},
        '{1'b0, 1'b0, 1'b0, SW, A_CH, 32'h0, 32'h00000000, 4'd9},
        // R7 privileged registers
        '{1'b1, 1'b1, 1'b0, SW, A_GM, 32'h12345678, 32'h0, 4'd7},
        '{1'b0, 1'b1, 1'b0, SW, A_GM, 32'h0, 32'h12345678, 4'd7},
        '{1'b0, 1'b0, 1'b0, SW, A_GM, 32'h0, 32'h00000000, 4'd7},
        '{1'b1, 1'b0, 1'b0, SW, A_GM, 32'h0, 32'h0, 4'd7},
        '{1'b1, 1'b1, 1'b1, SW, A_GM, 32'h0, 32'h0, 4'd7},
        '{1'b0, 1'b1, 1'b0, SW, A_GM, 32'h0, 32'h12345678, 4'd7},
        '{1'b0, 1'b1, 1'b1, SW, A_GM, 32'h0, 32'h00000000, 4'd7},
        '{1'b1, 1'b1, 1'b0, SW, A_NS, 32'hA5A5A5A5, 32'h0, 4'd7},
        '{1'b1, 1'b0, 1'b1, SW, A_NS, 32'h0, 32'h0, 4'd7},
        '{1'b0, 1'b1, 1'b0, SW, A_NS, 32'h0, 32'hA5A5A5A5, 4'd7},
        // R10 R12 undecoded offsets and sizes
        '{1'b1, 1'b1, 1'b0, SW, A_NONE, 32'hFFFFFFFF, 32'h0, 4'd10},
        '{1'b0, 1'b1, 1'b0, SW, A_NONE, 32'h0, 32'h00000000, 4'd10},
        '{1'b0, 1'b1, 1'b0, SB, A_GRP, 32'h0, 32'h00000000, 4'd10},
        '{1'b1, 1'b1, 1'b0, SB, A_GRP, 32'h0, 32'h0, 4'd10},
        '{1'b0, 1'b1, 1'b0, SW, A_GRP, 32'h0, 32'h7FFF0000, 4'd12},
        '{1'b0, 1'b1, 1'b0, SD, A_GRP, 32'h0, 32'h00000000, 4'd10},
        '{1'b1, 1'b1, 1'b0, SH, A_ES, 32'h0000FFFF, 32'h0, 4'd10},
        '{1'b0, 1'b1, 1'b0, SW, A_ES, 32'h0, 32'h0000000F, 4'd10},
        '{1'b0, 1'b1, 1'b0, SW, A_PR + 12'd2, 32'h0, 32'h00000000, 4'd10},
        '{1'b1, 1'b1, 1'b0, SW, A_PR + 12'd2, 32'hFFFFFFFF, 32'h0, 4'd10},
        '{1'b0, 1'b1, 1'b0, SW, A_PR, 32'h0, 32'h44332211, 4'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_secure = 1'b0;
    logic        sec_disable = 1'b0;
    logic [31:0] irq_level = '0;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pirq_regbank dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_size    (bus_size),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_secure  (bus_secure),
        .sec_disable (sec_disable),
        .irq_level   (irq_level),
        .bus_rdata   (bus_rdata)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic sec, input logic dis,
                          input logic [1:0] sz, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr      = wr;
        bus_rd      = !wr;
        bus_secure  = sec;
        sec_disable = dis;
        bus_size    = sz;
        bus_addr    = a;
        bus_wdata   = d;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    task automatic rd_check(input logic sec, input logic dis, input logic [1:0] sz,
                            input logic [11:0] a, input logic [31:0] exp, input int req,
                            input string what);
        access(1'b0, sec, dis, sz, a, 32'h0);
        check(bus_rdata, exp, req, what);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        rd_check(1'b1, 1'b0, SW, A_GRP, 32'h0, 11, "group after reset");
        rd_check(1'b1, 1'b0, SW, A_PS, 32'h0, 11, "pending after reset");
        rd_check(1'b1, 1'b0, SW, A_PR + 12'h1C, 32'h0, 11, "priority after reset");
        rd_check(1'b1, 1'b0, SW, A_GM, 32'h0, 11, "group modifier after reset");

        for (int k = 0; k < NV; k++) begin
            access(TBL[k].wr, TBL[k].sec, TBL[k].dis, TBL[k].size, TBL[k].addr, TBL[k].data);
            if (!TBL[k].wr)
                check(bus_rdata, TBL[k].exp, int'(TBL[k].req), $sformatf("vector %0d", k));
        end

        // R8 level lines fold into pending view; irq31 is edge-triggered
        irq_level = 32'h00010003;
        rd_check(1'b1, 1'b0, SW, A_PS, 32'h00010003, 8, "level view");
        irq_level = 32'h80010003;
        rd_check(1'b1, 1'b0, SW, A_PS, 32'h00010003, 8, "edge line not shown");
        access(1'b1, 1'b1, 1'b0, SW, A_PS, 32'h80000000);
        rd_check(1'b1, 1'b0, SW, A_PC, 32'h80010003, 8, "stored plus level");
        rd_check(1'b0, 1'b0, SW, A_PS, 32'h00010000, 8, "restricted pending view");
        access(1'b1, 1'b1, 1'b0, SW, A_PC, 32'h80000000);
        rd_check(1'b1, 1'b0, SW, A_PS, 32'h00010003, 8, "pending cleared");
        access(1'b1, 1'b0, 1'b0, SW, A_PS, 32'hFFFFFFFF);
        rd_check(1'b1, 1'b0, SW, A_PS, 32'h7FFF0003, 1, "restricted pending set");

        // R11 read data holds without a read strobe
        held = bus_rdata;
        access(1'b1, 1'b1, 1'b0, SW, A_ES, 32'hF0000000);
        repeat (3) @(negedge clk);
        check(bus_rdata, held, 11, "read data held");

        // R11 reset clears state mid-run
        irq_level = '0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_check(1'b1, 1'b0, SW, A_GM, 32'h0, 11, "group modifier cleared");
        rd_check(1'b1, 1'b0, SW, A_PR, 32'h0, 11, "priorities cleared");
        rd_check(1'b1, 1'b0, SW, A_CH, 32'h0, 11, "config cleared");
        rd_check(1'b1, 1'b0, SW, A_ES, 32'h0, 11, "enables cleared");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule